// File: doc/BRIEF.md
# Accumulator Add/Subtract Unit With Flags

This unit is the arithmetic slice of an 8-bit accumulator machine. It holds the accumulator and the five status flags (sign, zero, auxiliary carry, parity, carry). When a strobe arrives, it takes the opcode byte and one operand byte and decodes the opcode itself. It then performs one of the add or subtract variants, a complement of the accumulator, or a carry manipulation. Each add or subtract variant exists in two forms. In the register form the operand byte is the value of the selected working register. In the immediate form the operand byte is the data byte that follows the opcode.

Instruction fetch, memory and the register file sit outside this unit. The surrounding datapath places the right byte on the operand input. Register reference 7 is the exception: it names the accumulator itself, and the unit supplies that value internally. The accumulator and the packed status byte are outputs, and both are taken straight from flops.

Top module: `acc_arith_unit`

## Requirements
- R1: Synchronous active-high reset clears the accumulator to 0 and all five flags to 0, so the status output reads 8'h02.
- R2: Status byte layout: bit 7 is sign, bit 6 is zero, bit 4 is auxiliary carry, bit 2 is parity and bit 0 is carry. Bit 1 always reads 1, and bits 3 and 5 always read 0.
- R3: Opcode 8'o306 (immediate) and opcodes 8'o200..8'o207 (register) load (A + operand) mod 256 into A, ignoring the carry flag. Carry is set when the unsigned sum exceeds 255.
- R4: Opcode 8'o316 and opcodes 8'o210..8'o217 add the operand and the old carry flag to A. Carry is set when the sum exceeds 255.
- R5: Opcode 8'o326 and opcodes 8'o220..8'o227 load (A - operand) mod 256 into A. Carry acts as a borrow and is set when the operand exceeds A.
- R6: Opcode 8'o336 and opcodes 8'o230..8'o237 subtract both the operand and the old carry from A. Carry is set when operand + carry exceeds A.
- R7: After any add or subtract, sign equals bit 7 of the new A, zero is set when the new A is 0, and parity is set when the new A has an even number of 1 bits.
- R8: After an add, auxiliary carry is the carry out of bit 3. After a subtract, it is set when the low nibble of A is smaller than the low nibble of the operand plus the carry-in.
- R9: In register forms whose low three opcode bits are 7, the operand input is ignored and A is used as the operand. ADD A doubles A, and SUB A clears A and carry.
- R10: Opcode 8'o057 replaces A with its bitwise complement and leaves every flag unchanged.
- R11: Opcode 8'o067 sets carry and opcode 8'o077 inverts carry. Both leave A and the other flags unchanged.
- R12: A strobed operation is visible on the outputs after the clock edge that samples the strobe. Without a strobe, or with any opcode not listed above, A and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Execute the presented opcode this cycle |
| opcode | input | 8 | Instruction byte |
| operand | input | W (8) | Register value or immediate data byte |
| acc | output | W (8) | Accumulator register |
| status | output | 8 | Packed status byte |

## Verification
Every result has a latency of exactly one clock. The accumulator and the flags change on the rising edge that samples the strobe, and no other stage lies between the inputs and the outputs. The bench drives the opcode, the operand and the strobe on a falling edge. It drops the strobe on the next falling edge and compares both outputs there, half a period after they settle. Between operations the strobe is low, so a wrong update from a stale or idle cycle shows up as a changed value at the next comparison.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_ARITH,
    OP_CMPL,
    OP_SETC,
    OP_INVC
  } op_kind_t;

  typedef struct packed {
    op_kind_t kind;
    logic     is_sub;
    logic     use_cy;
    logic     self_src;
  } dec_t;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  localparam logic [7:0] OPC_CMPL = 8'o057;
  localparam logic [7:0] OPC_SETC = 8'o067;
  localparam logic [7:0] OPC_INVC = 8'o077;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [7:0] opc,
  output dec_t       dec
);
  always_comb begin
    dec          = '0;
    dec.kind     = OP_NONE;
    if (opc[7:5] == 3'b100) begin
      dec.kind     = OP_ARITH;
      dec.is_sub   = opc[4];
      dec.use_cy   = opc[3];
      dec.self_src = (opc[2:0] == 3'd7);
    end else if (opc[7:6] == 2'b11 && !opc[5] && opc[2:0] == 3'd6) begin
      dec.kind   = OP_ARITH;
      dec.is_sub = opc[4];
      dec.use_cy = opc[3];
    end else begin
      case (opc)
        OPC_CMPL: dec.kind = OP_CMPL;
        OPC_SETC: dec.kind = OP_SETC;
        OPC_INVC: dec.kind = OP_INVC;
        default:  dec.kind = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/acc_addsub.sv
module acc_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         is_sub,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         ac_out
);
  localparam int H = W / 2;

  logic [W-1:0] bx;
  logic         ci;
  logic [W:0]   full;
  logic [H:0]   low;

  always_comb begin
    bx     = is_sub ? ~b : b;
    ci     = is_sub ? ~cin : cin;
    full   = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, ci};
    low    = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, ci};
    res    = full[W-1:0];
    cy_out = full[W] ^ is_sub;
    ac_out = low[H] ^ is_sub;
  end
endmodule

// File: rtl/acc_flagcalc.sv
module acc_flagcalc
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  input  logic         cy,
  input  logic         ac,
  output flags_t       flg
);
  always_comb begin
    flg.s  = res[W-1];
    flg.z  = (res == '0);
    flg.ac = ac;
    flg.p  = ~^res;
    flg.cy = cy;
  end
endmodule

// File: rtl/acc_arith_unit.sv
module acc_arith_unit
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [7:0]   opcode,
  input  logic [W-1:0] operand,
  output logic [W-1:0] acc,
  output logic [7:0]   status
);
  dec_t         dec;
  flags_t       flg_q, flg_new;
  logic [W-1:0] acc_q, src, sum;
  logic         cy_n, ac_n;

  acc_decode u_dec (.opc(opcode), .dec(dec));

  assign src = dec.self_src ? acc_q : operand;

  acc_addsub #(.W(W)) u_alu (
    .a(acc_q), .b(src), .cin(dec.use_cy & flg_q.cy), .is_sub(dec.is_sub),
    .res(sum), .cy_out(cy_n), .ac_out(ac_n)
  );

  acc_flagcalc #(.W(W)) u_flg (
    .res(sum), .cy(cy_n), .ac(ac_n), .flg(flg_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (strobe) begin
      case (dec.kind)
        OP_ARITH: begin
          acc_q <= sum;
          flg_q <= flg_new;
        end
        OP_CMPL: acc_q    <= ~acc_q;
        OP_SETC: flg_q.cy <= 1'b1;
        OP_INVC: flg_q.cy <= ~flg_q.cy;
        default: ;
      endcase
    end
  end

  assign acc    = acc_q;
  assign status = {flg_q.s, flg_q.z, 1'b0, flg_q.ac, 1'b0, flg_q.p, 1'b1, flg_q.cy};
endmodule

// File: rtl/acc_arith_chk.sv
module acc_arith_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         strobe,
  input logic [7:0]   opcode,
  input logic [W-1:0] acc,
  input logic [7:0]   status
);
  logic is_ar;
  assign is_ar = (opcode[7:5] == 3'b100) ||
                 (opcode[7:6] == 2'b11 && !opcode[5] && opcode[2:0] == 3'd6);

  a_r7_result_flags: assert property (@(posedge clk) disable iff (rst)
    strobe && is_ar |=> (status[6] == (acc == '0)) && (status[7] == acc[W-1]) && (status[2] == ~^acc));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(acc) && $stable(status));

  a_r10_cmpl: assert property (@(posedge clk) disable iff (rst)
    strobe && opcode == 8'o057 |=> (acc == ~$past(acc)) && $stable(status));

  a_r11_setc: assert property (@(posedge clk) disable iff (rst)
    strobe && opcode == 8'o067 |=> status[0] && $stable(acc) && (status[7:1] == $past(status[7:1])));

  a_r11_invc: assert property (@(posedge clk) disable iff (rst)
    strobe && opcode == 8'o077 |=> (status[0] != $past(status[0])) && $stable(acc));

  a_r9_self_clear: assert property (@(posedge clk) disable iff (rst)
    strobe && opcode == 8'o227 |=> (acc == '0) && !status[0]);
endmodule

bind acc_arith_unit acc_arith_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .opcode(opcode), .acc(acc), .status(status)
);

// File: tb/sim_acc_arith_unit.sv
module sim_acc_arith_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc, status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_a = 0, m_cy = 0, m_s = 0, m_z = 0, m_ac = 0, m_p = 0;

  always #10 clk = ~clk;

  acc_arith_unit #(.W(8)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe), .opcode(opcode),
    .operand(operand), .acc(acc), .status(status)
  );

  function automatic logic [7:0] m_status();
    return {m_s[0], m_z[0], 1'b0, m_ac[0], 1'b0, m_p[0], 1'b1, m_cy[0]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] opc, input logic [7:0] val);
    @(negedge clk);
    strobe = 1'b1; opcode = opc; operand = val;
    @(negedge clk);
    strobe = 1'b0; opcode = 8'h00;
  endtask

  task automatic model_arith(input int sub, input int usec, input int b);
    int c, r;
    c = usec ? m_cy : 0;
    if (sub == 0) begin
      r = m_a + b + c;
      m_cy = (r > 255);
      m_ac = ((m_a % 16) + (b % 16) + c) > 15;
    end else begin
      r = m_a - b - c;
      m_cy = (r < 0);
      m_ac = ((m_a % 16) - (b % 16) - c) < 0;
    end
    m_a = (r + 512) % 256;
    m_s = m_a / 128;
    m_z = (m_a == 0);
    m_p = ($countones(m_a[7:0]) % 2) == 0;
  endtask

  task automatic load_a(input int v, input int c);
    issue(8'o227, 8'h5A); model_arith(1, 0, m_a);
    issue(8'o306, v[7:0]); model_arith(0, 0, v);
    issue(8'o067, 8'h00); m_cy = 1;
    if (c == 0) begin issue(8'o077, 8'h00); m_cy = 0; end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int avals [8] = '{0, 1, 15, 16, 127, 128, 200, 255};
    string tags [4] = '{"R3", "R4", "R5", "R6"};
    logic [7:0] hold_a, hold_s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 acc", acc, 8'h00);
    chk("R1 R2 status", status, 8'h02);

    // R3 wraparound example
    load_a(25, 0); issue(8'o306, 8'd245); model_arith(0, 0, 245);
    chk("R3 acc", acc, 8'd14); chk("R3 carry", {7'd0, status[0]}, 8'd1);
    // R5 borrow example
    load_a(12, 0); issue(8'o326, 8'd25); model_arith(1, 0, 25);
    chk("R5 acc", acc, 8'o363); chk("R5 borrow", {7'd0, status[0]}, 8'd1);
    // R2 reserved bits with all flags active
    load_a(8'h88, 0); issue(8'o306, 8'h88); model_arith(0, 0, 8'h88);
    chk("R2 reserved", status & 8'h2A, 8'h02);

    // R9 self operand
    load_a(8'h41, 1); issue(8'o207, 8'hFF); model_arith(0, 0, 8'h41);
    chk("R9 add self", acc, 8'h82);
    load_a(8'h37, 1); issue(8'o227, 8'h01);
    chk("R9 sub self acc", acc, 8'h00);
    chk("R9 sub self status", status, 8'h46);
    model_arith(1, 0, 8'h37);
    load_a(8'h90, 1); issue(8'o237, 8'h00); model_arith(1, 1, 8'h90);
    chk("R9 sbb self", acc, 8'hFF); chk("R9 sbb self status", status, m_status());

    // R10 complement keeps flags
    load_a(8'h3C, 1); hold_s = status;
    issue(8'o057, 8'h12);
    chk("R10 acc", acc, 8'hC3); chk("R10 flags", status, hold_s);

    // R11 carry control
    hold_a = acc; hold_s = status;
    issue(8'o077, 8'h00);
    chk("R11 invert", status, hold_s ^ 8'h01); chk("R11 acc", acc, hold_a);
    issue(8'o067, 8'h00);
    chk("R11 set", status, hold_s | 8'h01);
    issue(8'o067, 8'h00);
    chk("R11 set again", status, hold_s | 8'h01);

    // R12 idle and undefined opcodes
    hold_a = acc; hold_s = status;
    @(negedge clk); opcode = 8'o306; operand = 8'h55; @(negedge clk); opcode = 8'h00;
    chk("R12 idle acc", acc, hold_a); chk("R12 idle status", status, hold_s);
    issue(8'o000, 8'h77); issue(8'o100, 8'h77); issue(8'o346, 8'h77); issue(8'o376, 8'h77);
    chk("R12 undef acc", acc, hold_a); chk("R12 undef status", status, hold_s);

    // R3..R8 sweep over both forms and both carry-in values
    foreach (avals[i]) begin
      for (int b = 0; b < 256; b++) begin
        for (int v = 0; v < 4; v++) begin
          for (int c = 0; c < 2; c++) begin
            logic [7:0] opc;
            load_a(avals[i], c);
            if ((b + v) % 2 == 0) opc = 8'o306 | 8'(v << 3);
            else opc = 8'o200 | 8'(v << 3) | 8'(b % 7);
            issue(opc, b[7:0]);
            model_arith(v / 2, v % 2, b);
            chk(tags[v], acc, m_a[7:0]);
            chk("R7 R8 status", status, m_status());
          end
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule